// File: doc/BRIEF.md
# CAN Receive Frame Buffer

This block holds received CAN frames until the host has read them. Each frame arrives as a run of bytes followed by an end-of-frame strobe that carries the frame's byte count. The bytes sit back to back in a circular byte store with no gaps between frames. A second, small queue keeps one length entry per stored frame, so the buffer knows where each frame ends.

The host sees the oldest stored frame through a window of register addresses. Window offset k returns the byte k places after the start of that frame. The host then asks for a release to drop the frame, which advances the read side by the frame's stored length. The release request is a level signal. Only its rising edge counts, so a request held for many cycles frees a single frame.

A frame that does not fit is dropped whole, and a sticky overrun flag records the loss. A frame does not fit when the free byte space is smaller than its length, or when the length queue is full. After each reset an initialisation sweep clears every length entry, so that no stale length survives. No frame is accepted until that sweep is done.

Top module: `can_rx_frame_buffer`

## Requirements
- R1: Bytes of consecutive accepted frames are stored contiguously with no padding. After a 5-byte frame and a 4-byte frame, the first byte of the second frame appears at window offset 0 once the first frame has been released.
- R2: `head_len` shows the byte count of the oldest stored frame, taken from a length queue that holds one entry per accepted frame.
- R3: An effective release removes one frame. It lowers `msg_count` by one and moves the window start forward by that frame's length.
- R4: A release acts only in the cycle where `release_req` is high and was low in the cycle before. Holding the request high for several cycles releases exactly one frame.
- R5: Host addresses 16 to 31 form the read window. Address 16+k returns the byte at the oldest frame's start plus k, modulo 64. Every other address returns 0.
- R6: After reset, `init_done` stays low for exactly 64 clock cycles while every length entry is written to zero. Once the sweep ends, `head_len` reads 0 with no frame stored. A frame end that arrives during the sweep is dropped and sets `overrun`.
- R7: A frame end is dropped if `frame_len` exceeds the free byte space (64 minus the stored bytes) or if 64 frames are already stored. A dropped frame leaves `msg_count` unchanged and sets `overrun`, which stays set until reset. A frame that exactly fills the free space is accepted.
- R8: A release while `msg_count` is 0 has no effect. The count stays 0, `overrun` is unchanged, and a frame committed afterwards is read correctly from window offset 0.
- R9: A frame end and an effective release in the same cycle both take effect. `msg_count` stays the same, the new frame is stored and the oldest frame is removed.
- R10: While `rst_n` is low (synchronous, active low), `msg_count` is 0, `overrun` is 0 and `init_done` is 0.
- R11: Byte storage and length storage wrap modulo 64, so frames that straddle the end of the byte store read back correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_we | input | 1 | Write one byte of the frame being received |
| byte_in | input | 8 | Byte value written when `byte_we` is high |
| frame_end | input | 1 | End-of-frame strobe; commits or drops the frame |
| frame_len | input | 4 | Byte count of the frame closed by `frame_end` |
| host_addr | input | 8 | Host read address; window at 16..31 |
| host_rdata | output | 8 | Byte read through the window, 0 outside it |
| release_req | input | 1 | Level request to release the oldest frame |
| msg_count | output | 7 | Number of stored frames, 0..64 |
| head_len | output | 4 | Length of the oldest stored frame |
| overrun | output | 1 | Sticky: a frame was dropped |
| init_done | output | 1 | Length-queue clearing sweep has finished |

## Verification
A frame commit and a frame release can fall in the same clock edge. Both move the byte occupancy, the frame count and a pointer pair at once. The bench provokes this on purpose by raising `frame_end` together with a fresh rising edge of `release_req`. It does so in directed steps and also as one of the random operations. A bench model works out acceptance from the occupancy before the edge and applies both effects. It then compares the count, the overrun flag, the head length and every byte of the new oldest frame seen through the window. The same-edge case is also run near a full buffer, where the commit's fit test must use the space that existed before the release.

// File: rtl/rxfb_pkg.sv
// Package: shared types for the receive frame buffer.
// Assumes byte-wide frame data throughout.
package rxfb_pkg;
    typedef logic [7:0] rx_byte_t;

    // Outcome of an end-of-frame strobe.
    typedef struct packed {
        logic accept;
        logic drop;
    } commit_dec_t;
endpackage

// File: rtl/rxfb_release_edge.sv
// Module: rxfb_release_edge
// Turns a level release request into a single-cycle pulse, issued in the
// first cycle the request is seen high. Assumes req is synchronous to clk.
module rxfb_release_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic pulse
);
    logic req_q;

    // Remember the request level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= req;
    end

    // Rising edge of the request.
    always_comb pulse = req & ~req_q;
endmodule

// File: rtl/rxfb_data_store.sv
// Module: rxfb_data_store
// Circular byte store with one write port and a host read window. Window
// offset k maps to rd_base+k modulo the store depth. Assumes WIN_SIZE is no
// larger than the depth. Contents are not reset.
module rxfb_data_store
    import rxfb_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int HADDR_W  = 8,
    parameter int WIN_BASE = 16,
    parameter int WIN_SIZE = 16
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  rx_byte_t           wr_byte,
    input  logic [ADDR_W-1:0]  rd_base,
    input  logic [HADDR_W-1:0] host_addr,
    output rx_byte_t           host_rdata
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [HADDR_W-1:0] WLO = HADDR_W'(WIN_BASE);
    localparam logic [HADDR_W-1:0] WHI = HADDR_W'(WIN_BASE + WIN_SIZE);

    rx_byte_t            mem [DEPTH];
    logic                in_win;
    logic [ADDR_W-1:0]   offset;
    logic [ADDR_W-1:0]   rd_addr;

    // Store one byte per write strobe.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_byte;
    end

    // Decode the window and fetch the byte relative to the read pointer.
    always_comb begin
        in_win     = (host_addr >= WLO) && (host_addr < WHI);
        offset     = ADDR_W'(host_addr - WLO);
        rd_addr    = rd_base + offset;
        host_rdata = in_win ? mem[rd_addr] : '0;
    end
endmodule

// File: rtl/rxfb_len_queue.sv
// Module: rxfb_len_queue
// One length entry per stored frame, written at the write-info pointer and
// read at the read-info pointer. After reset it sweeps every entry to zero
// before it reports ready. Assumes push never arrives while init_done is low
// and pop never arrives with the queue empty (the caller gates both).
module rxfb_len_queue #(
    parameter int ADDR_W = 6,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [LEN_W-1:0]  push_len,
    input  logic              pop,
    output logic [LEN_W-1:0]  head_len,
    output logic              init_done
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [LEN_W-1:0]  len_mem [DEPTH];
    logic [ADDR_W-1:0] wr_info;
    logic [ADDR_W-1:0] rd_info;
    logic [ADDR_W-1:0] sweep_idx;
    logic              sweeping;

    // Clearing sweep: runs from reset until the index reaches all ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sweeping  <= 1'b1;
            sweep_idx <= '0;
        end else if (sweeping) begin
            sweep_idx <= sweep_idx + 1'b1;
            if (&sweep_idx) sweeping <= 1'b0;
        end
    end

    // Length entries: zero during the sweep, the frame length on push.
    always_ff @(posedge clk) begin
        if (sweeping)  len_mem[sweep_idx] <= '0;
        else if (push) len_mem[wr_info]   <= push_len;
    end

    // Info pointers advance one entry per push or pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_info <= '0;
            rd_info <= '0;
        end else begin
            if (push) wr_info <= wr_info + 1'b1;
            if (pop)  rd_info <= rd_info + 1'b1;
        end
    end

    // Oldest entry and ready flag.
    always_comb begin
        head_len  = len_mem[rd_info];
        init_done = ~sweeping;
    end
endmodule

// File: rtl/can_rx_frame_buffer.sv
// Module: can_rx_frame_buffer
// Frame-oriented receive buffer. Bytes of a frame are staged into free space
// behind the write pointer and committed by an end-of-frame strobe with the
// frame length; a frame that does not fit, or arrives during the clearing
// sweep, is dropped and flags overrun. A release (rising edge of the request)
// frees the oldest frame. Assumes frame_len equals the bytes written for it.
module can_rx_frame_buffer
    import rxfb_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int LEN_W    = 4,
    parameter int HADDR_W  = 8,
    parameter int WIN_BASE = 16,
    parameter int WIN_SIZE = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               byte_we,
    input  logic [7:0]         byte_in,
    input  logic               frame_end,
    input  logic [LEN_W-1:0]   frame_len,
    input  logic [HADDR_W-1:0] host_addr,
    output logic [7:0]         host_rdata,
    input  logic               release_req,
    output logic [ADDR_W:0]    msg_count,
    output logic [LEN_W-1:0]   head_len,
    output logic               overrun,
    output logic               init_done
);
    localparam int CNT_W = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [ADDR_W-1:0] wr_ptr;
    logic [ADDR_W-1:0] rd_ptr;
    logic [CNT_W-1:0]  used_bytes;
    logic [CNT_W-1:0]  stage_cnt;
    logic [CNT_W-1:0]  free_bytes;
    logic [CNT_W-1:0]  len_ext;
    logic [CNT_W-1:0]  add_bytes;
    logic [CNT_W-1:0]  sub_bytes;
    logic              rel_pulse;
    logic              rel_ok;
    logic              stage_we;
    logic [ADDR_W-1:0] stage_addr;
    commit_dec_t       dec;

    rxfb_release_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (release_req),
        .pulse (rel_pulse)
    );

    rxfb_len_queue #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_lenq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (dec.accept),
        .push_len  (frame_len),
        .pop       (rel_ok),
        .head_len  (head_len),
        .init_done (init_done)
    );

    rxfb_data_store #(
        .ADDR_W   (ADDR_W),
        .HADDR_W  (HADDR_W),
        .WIN_BASE (WIN_BASE),
        .WIN_SIZE (WIN_SIZE)
    ) u_store (
        .clk        (clk),
        .wr_en      (stage_we),
        .wr_addr    (stage_addr),
        .wr_byte    (byte_in),
        .rd_base    (rd_ptr),
        .host_addr  (host_addr),
        .host_rdata (host_rdata)
    );

    // Space check, commit decision and release qualification.
    always_comb begin
        free_bytes = FULL - used_bytes;
        len_ext    = CNT_W'(frame_len);
        dec.accept = frame_end && init_done && (msg_count != FULL)
                     && (len_ext <= free_bytes);
        dec.drop   = frame_end && !dec.accept;
        rel_ok     = rel_pulse && (msg_count != '0);
        add_bytes  = dec.accept ? len_ext : '0;
        sub_bytes  = rel_ok ? CNT_W'(head_len) : '0;
        stage_we   = byte_we && (stage_cnt < free_bytes);
        stage_addr = wr_ptr + stage_cnt[ADDR_W-1:0];
    end

    // Byte position inside the frame being received.
    always_ff @(posedge clk) begin
        if (!rst_n)                          stage_cnt <= '0;
        else if (frame_end)                  stage_cnt <= '0;
        else if (byte_we && stage_cnt != FULL) stage_cnt <= stage_cnt + 1'b1;
    end

    // Data pointers and byte occupancy; commit and release may coincide.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr     <= '0;
            rd_ptr     <= '0;
            used_bytes <= '0;
        end else begin
            wr_ptr     <= wr_ptr + add_bytes[ADDR_W-1:0];
            rd_ptr     <= rd_ptr + sub_bytes[ADDR_W-1:0];
            used_bytes <= used_bytes + add_bytes - sub_bytes;
        end
    end

    // Stored-frame counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                     msg_count <= '0;
        else if (dec.accept && !rel_ok) msg_count <= msg_count + 1'b1;
        else if (!dec.accept && rel_ok) msg_count <= msg_count - 1'b1;
    end

    // Sticky overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n)       overrun <= 1'b0;
        else if (dec.drop) overrun <= 1'b1;
    end
endmodule

// File: rtl/can_rx_frame_buffer_chk.sv
// Module: can_rx_frame_buffer_chk
// Port-level properties of the receive frame buffer, bound to the top.
module can_rx_frame_buffer_chk #(
    parameter int ADDR_W = 6,
    parameter int LEN_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_end,
    input logic [LEN_W-1:0]  frame_len,
    input logic              release_req,
    input logic [ADDR_W:0]   msg_count,
    input logic              overrun,
    input logic              init_done
);
    localparam int DEPTH = 1 << ADDR_W;

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(msg_count) <= DEPTH); // R7
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun); // R7
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && int'(msg_count) == DEPTH) |=> overrun); // R7
    AST_INIT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && !init_done) |=> overrun); // R6
    AST_INIT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> msg_count == '0); // R6
    AST_EMPTY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_count == '0 && !frame_end) |=> msg_count == '0); // R8
    AST_HELD_NO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (release_req && $past(release_req) && !frame_end) |=> $stable(msg_count)); // R4
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(msg_count) <= int'($past(msg_count)) + 1) &&
        (int'(msg_count) + 1 >= int'($past(msg_count)))); // R9
    AST_FRAMELEN_USED: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && frame_len == '0 && init_done && int'(msg_count) < DEPTH
         && !release_req) |=> int'(msg_count) == int'($past(msg_count)) + 1); // R7
endmodule

bind can_rx_frame_buffer can_rx_frame_buffer_chk #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_end   (frame_end),
    .frame_len   (frame_len),
    .release_req (release_req),
    .msg_count   (msg_count),
    .overrun     (overrun),
    .init_done   (init_done)
);

// File: tb/can_rx_frame_buffer_test.sv
module can_rx_frame_buffer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_we = 1'b0;
    logic [7:0] byte_in = '0;
    logic       frame_end = 1'b0;
    logic [3:0] frame_len = '0;
    logic [7:0] host_addr = '0;
    logic [7:0] host_rdata;
    logic       release_req = 1'b0;
    logic [6:0] msg_count;
    logic [3:0] head_len;
    logic       overrun;
    logic       init_done;

    int checks = 0;
    int failures = 0;

    // Bench model: unread bytes in order, lengths of stored frames.
    int m_bytes[$];
    int m_lens[$];
    bit m_ovr;

    always #4 clk = ~clk;

    can_rx_frame_buffer uut (
        .clk(clk), .rst_n(rst_n), .byte_we(byte_we), .byte_in(byte_in),
        .frame_end(frame_end), .frame_len(frame_len), .host_addr(host_addr),
        .host_rdata(host_rdata), .release_req(release_req),
        .msg_count(msg_count), .head_len(head_len), .overrun(overrun),
        .init_done(init_done)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic bit model_fits(int len);
        return (len <= 64 - m_bytes.size()) && (m_lens.size() < 64);
    endfunction

    task automatic model_release();
        if (m_lens.size() > 0) begin
            int n = m_lens.pop_front();
            for (int i = 0; i < n; i++) void'(m_bytes.pop_front());
        end
    endtask

    // Send one frame; optionally raise a fresh release in the commit cycle.
    task automatic send_frame(int len, bit with_rel);
        int vals[$];
        bit fits;
        for (int i = 0; i < len; i++) begin
            vals.push_back(int'($urandom_range(255)));
            byte_we = 1'b1;
            byte_in = 8'(vals[i]);
            tick();
        end
        byte_we   = 1'b0;
        frame_end = 1'b1;
        frame_len = 4'(len);
        release_req = with_rel;
        fits = init_done && model_fits(len);
        tick();
        frame_end = 1'b0;
        release_req = 1'b0;
        if (with_rel) model_release();
        if (fits) begin
            m_lens.push_back(len);
            foreach (vals[i]) m_bytes.push_back(vals[i]);
        end else m_ovr = 1'b1;
        tick();
    endtask

    task automatic release_frame(int hold);
        release_req = 1'b1;
        for (int i = 0; i < hold; i++) tick();
        release_req = 1'b0;
        model_release();
        tick();
    endtask

    // Compare count, flag, head length and head frame bytes with the model.
    task automatic compare(string req);
        check({req, " count"}, int'(msg_count), m_lens.size());
        check({req, " overrun"}, int'(overrun), int'(m_ovr));
        if (m_lens.size() > 0) begin
            check({req, " head_len"}, int'(head_len), m_lens[0]);
            for (int k = 0; k < m_lens[0]; k++) begin
                host_addr = 8'(16 + k);
                #1;
                check({req, " window"}, int'(host_rdata), m_bytes[k]);
            end
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        tick();
        check("R10 count in reset", int'(msg_count), 0);
        check("R10 overrun in reset", int'(overrun), 0);
        check("R10 init_done in reset", int'(init_done), 0);
        m_bytes.delete();
        m_lens.delete();
        m_ovr = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic wait_init();
        int n = 0;
        while (!init_done && n < 200) begin
            tick();
            n++;
        end
        check("R6 init cycles", n, 64);
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        do_reset();
        // R6: a frame end during the sweep is dropped.
        tick();
        tick();
        frame_end = 1'b1;
        frame_len = 4'd2;
        tick();
        frame_end = 1'b0;
        check("R6 drop during init overrun", int'(overrun), 1);
        check("R6 drop during init count", int'(msg_count), 0);

        do_reset();
        wait_init();
        check("R6 head_len cleared", int'(head_len), 0);
        // R1/R2/R5: 5-byte then 4-byte frame.
        send_frame(5, 1'b0);
        send_frame(4, 1'b0);
        compare("R1 R2 R5 two frames");
        host_addr = 8'd15;
        #1;
        check("R5 below window", int'(host_rdata), 0);
        host_addr = 8'd32;
        #1;
        check("R5 above window", int'(host_rdata), 0);
        // R4/R3: held request frees one frame.
        release_frame(5);
        check("R4 held release count", int'(msg_count), 1);
        compare("R1 R3 second frame at offset 0");
        release_frame(1);
        check("R3 empty after releases", int'(msg_count), 0);
        // R8: release while empty.
        release_frame(1);
        check("R8 empty release count", int'(msg_count), 0);
        check("R8 empty release overrun", int'(overrun), 0);
        send_frame(3, 1'b0);
        compare("R8 frame after empty release");
        // R6: stale lengths cleared by reset sweep (entry 0 held 5).
        do_reset();
        wait_init();
        check("R6 stale length cleared", int'(head_len), 0);
        // R7: space limit and exact fit.
        for (int i = 0; i < 4; i++) send_frame(13, 1'b0);
        send_frame(13, 1'b0);
        compare("R7 drop on no space");
        send_frame(12, 1'b0);
        compare("R7 exact fit accepted");
        // R9 near full: commit fit judged before release.
        send_frame(1, 1'b1);
        compare("R9 commit with release when full");
        while (m_lens.size() > 0) release_frame(1);
        // R11/R9: wrap with overlapping commit and release.
        for (int i = 0; i < 12; i++) send_frame(9 + (i % 4), i % 2 == 1);
        compare("R11 R9 wrap");
        // R7: length queue full with empty frames.
        do_reset();
        wait_init();
        for (int i = 0; i < 64; i++) send_frame(0, 1'b0);
        check("R7 queue full count", int'(msg_count), 64);
        check("R7 no overrun at 64", int'(overrun), 0);
        send_frame(0, 1'b0);
        check("R7 queue full drop count", int'(msg_count), 64);
        check("R7 queue full overrun", int'(overrun), 1);
        // Random mix.
        do_reset();
        wait_init();
        for (int it = 0; it < 600; it++) begin
            int op = int'($urandom_range(9));
            if (op < 4)      send_frame(int'($urandom_range(13)), 1'b0);
            else if (op < 7) release_frame(int'($urandom_range(1, 3)));
            else             send_frame(int'($urandom_range(13)), 1'b1);
            compare("R3 R9 R11 random");
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule